// File: doc/BRIEF.md
# Transceiver Loopback Path Selector

This block sits in one channel of a serializer/deserializer and decides where each data word goes. In normal operation the parallel transmit word goes to the serializer, and the word from the deserializer goes to the parallel receive outputs. Three test paths can replace this. The **deep** path loops the transmit serial stream back into the channel's own serial input and turns off the external serial driver. The **shallow** path sends the parallel transmit word straight to the parallel receive outputs. The **far-end** path sends the received serial word back out of the transmitter and ignores the parallel transmit input. The serial side is modelled as parallel words, with one word per clock.

Per-channel control bits select a mode. A global loopback pin forces deep loopback on every channel, and it passes through a two-flop synchronizer before it is used. A separate control bit disables the parallel outputs. When more than one mode is requested, the block applies a fixed priority. A mode change takes effect on the next word, and the receive word for that switch is marked invalid.

Top module: `lbsel_top`

## Requirements
- R1: While `rst` is high, all data outputs are zero and `tx_ser_oe_o`, `rx_par_oe_o` and `rx_vld_o` are low. After the first clock edge with `rst` low, the block is in normal mode.
- R2: Normal mode (no request): one edge after the inputs are sampled, `tx_ser_o` equals `tx_par_i`, `rx_par_o` equals `rx_ser_i`, and `tx_ser_oe_o` is 1.
- R3: Deep mode requested by `cfg_deep_i`: `rx_par_o` and `tx_ser_o` both equal the sampled `tx_par_i`, and `tx_ser_oe_o` is 0.
- R4: A high level on `lpbk_all_i` forces deep mode, and it also overrides a far-end request. The pin goes through two synchronizer flops, so the outputs change on the third clock edge after the pin changes.
- R5: Shallow mode (`cfg_shallow_i`): `rx_par_o` and `tx_ser_o` equal the sampled `tx_par_i`, and `tx_ser_oe_o` stays 1.
- R6: Far-end mode (`cfg_far_i`): `tx_ser_o` and `rx_par_o` equal the sampled `rx_ser_i`, `tx_par_i` has no effect on either, and `tx_ser_oe_o` is 1.
- R7: When several modes are requested at once, shallow wins over deep, and deep wins over far-end.
- R8: `rx_par_oe_o` equals the inverse of `cfg_par_hiz_i` one edge later, whatever the mode.
- R9: Every mode change is registered at a word boundary. For exactly the one output word that follows the change, `rx_vld_o` is 0, and the data already follows the new mode. With no change, `rx_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| lpbk_all_i | input | 1 | Asynchronous global pin forcing deep loopback |
| cfg_deep_i | input | 1 | Channel request for deep loopback |
| cfg_shallow_i | input | 1 | Channel request for shallow loopback |
| cfg_far_i | input | 1 | Channel request for far-end loopback |
| cfg_par_hiz_i | input | 1 | Disable the parallel receive outputs |
| tx_par_i | input | W | Parallel transmit word |
| rx_ser_i | input | W | Word arriving from the serial input |
| tx_ser_o | output | W | Word sent to the serializer |
| tx_ser_oe_o | output | 1 | Enable for the external serial driver |
| rx_par_o | output | W | Parallel receive word |
| rx_par_oe_o | output | 1 | Enable for the parallel receive outputs |
| rx_vld_o | output | 1 | Receive word valid; low for one word after a mode switch |

## Verification
The hardest case to reach is the exact cycle in which the synchronized global pin takes over. It is the only input whose effect is delayed by two extra edges, and the override must also hold against a far-end request that is already active. The bench keeps the channel stable in normal mode, raises the pin in a known cycle and checks the serial enable on each of the following edges. Only the third edge may show deep mode, and that word must carry a cleared valid flag. The test then repeats the same sequence with a far-end request already active.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;
  typedef enum logic [1:0] {
    LB_NORMAL  = 2'd0,
    LB_SHALLOW = 2'd1,
    LB_DEEP    = 2'd2,
    LB_FAR     = 2'd3
  } lb_mode_e;
endpackage

// File: rtl/lbsel_sync.sv
module lbsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lbsel_decode.sv
module lbsel_decode
  import lbsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_sync_i,
  input  logic     deep_i,
  input  logic     shallow_i,
  input  logic     far_i,
  output lb_mode_e req_o,
  output lb_mode_e mode_q_o,
  output logic     switch_o
);
  always_comb begin
    if (shallow_i)                req_o = LB_SHALLOW;
    else if (deep_i || pin_sync_i) req_o = LB_DEEP;
    else if (far_i)               req_o = LB_FAR;
    else                          req_o = LB_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q_o <= LB_NORMAL;
    else     mode_q_o <= req_o;
  end

  assign switch_o = (req_o != mode_q_o);
endmodule

// File: rtl/lbsel_steer.sv
module lbsel_steer
  import lbsel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  lb_mode_e     req_i,
  input  logic         switch_i,
  input  logic         par_hiz_i,
  input  logic [W-1:0] tx_par_i,
  input  logic [W-1:0] rx_ser_i,
  output logic [W-1:0] tx_ser_o,
  output logic         tx_ser_oe_o,
  output logic [W-1:0] rx_par_o,
  output logic         rx_par_oe_o,
  output logic         rx_vld_o
);
  logic [W-1:0] tx_d, rx_d;
  logic         soe_d;

  always_comb begin
    tx_d  = tx_par_i;
    rx_d  = rx_ser_i;
    soe_d = 1'b1;
    unique case (req_i)
      LB_SHALLOW: rx_d = tx_par_i;
      LB_DEEP: begin
        rx_d  = tx_par_i;
        soe_d = 1'b0;
      end
      LB_FAR:  tx_d = rx_ser_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ser_o    <= '0;
      rx_par_o    <= '0;
      tx_ser_oe_o <= 1'b0;
      rx_par_oe_o <= 1'b0;
      rx_vld_o    <= 1'b0;
    end else begin
      tx_ser_o    <= tx_d;
      rx_par_o    <= rx_d;
      tx_ser_oe_o <= soe_d;
      rx_par_oe_o <= ~par_hiz_i;
      rx_vld_o    <= ~switch_i;
    end
  end
endmodule

// File: rtl/lbsel_top.sv
module lbsel_top
  import lbsel_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lpbk_all_i,
  input  logic         cfg_deep_i,
  input  logic         cfg_shallow_i,
  input  logic         cfg_far_i,
  input  logic         cfg_par_hiz_i,
  input  logic [W-1:0] tx_par_i,
  input  logic [W-1:0] rx_ser_i,
  output logic [W-1:0] tx_ser_o,
  output logic         tx_ser_oe_o,
  output logic [W-1:0] rx_par_o,
  output logic         rx_par_oe_o,
  output logic         rx_vld_o
);
  logic     pin_sync;
  lb_mode_e req;
  lb_mode_e mode_q;
  logic     switch_w;

  lbsel_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (lpbk_all_i),
    .q_o (pin_sync)
  );

  lbsel_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .pin_sync_i (pin_sync),
    .deep_i     (cfg_deep_i),
    .shallow_i  (cfg_shallow_i),
    .far_i      (cfg_far_i),
    .req_o      (req),
    .mode_q_o   (mode_q),
    .switch_o   (switch_w)
  );

  lbsel_steer #(.W(W)) u_steer (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req),
    .switch_i    (switch_w),
    .par_hiz_i   (cfg_par_hiz_i),
    .tx_par_i    (tx_par_i),
    .rx_ser_i    (rx_ser_i),
    .tx_ser_o    (tx_ser_o),
    .tx_ser_oe_o (tx_ser_oe_o),
    .rx_par_o    (rx_par_o),
    .rx_par_oe_o (rx_par_oe_o),
    .rx_vld_o    (rx_vld_o)
  );
endmodule

// File: rtl/lbsel_chk.sv
module lbsel_chk
  import lbsel_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input lb_mode_e     mode_q,
  input logic         cfg_par_hiz_i,
  input logic [W-1:0] tx_par_i,
  input logic [W-1:0] rx_ser_i,
  input logic [W-1:0] tx_ser_o,
  input logic         tx_ser_oe_o,
  input logic [W-1:0] rx_par_o,
  input logic         rx_par_oe_o,
  input logic         rx_vld_o
);
  AST_DEEP_DRV_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_DEEP) |-> !tx_ser_oe_o); // R3

  AST_SHALLOW_PATH: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_SHALLOW && !$past(rst)) |-> (rx_par_o == $past(tx_par_i) && tx_ser_oe_o)); // R5

  AST_FAR_PATH: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_FAR && !$past(rst)) |-> (tx_ser_o == $past(rx_ser_i))); // R6

  AST_PAR_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rx_par_oe_o == !$past(cfg_par_hiz_i))); // R8

  AST_SWITCH_INVALID: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_q != $past(mode_q)) |-> !rx_vld_o); // R9

  AST_STEADY_VALID: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_q == $past(mode_q)) |-> rx_vld_o); // R9
endmodule

bind lbsel_top lbsel_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_q        (mode_q),
  .cfg_par_hiz_i (cfg_par_hiz_i),
  .tx_par_i      (tx_par_i),
  .rx_ser_i      (rx_ser_i),
  .tx_ser_o      (tx_ser_o),
  .tx_ser_oe_o   (tx_ser_oe_o),
  .rx_par_o      (rx_par_o),
  .rx_par_oe_o   (rx_par_oe_o),
  .rx_vld_o      (rx_vld_o)
);

// File: tb/sim_lbsel_top.sv
`timescale 1ns/1ps
module sim_lbsel_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pin = 1'b0, c_deep = 1'b0, c_sh = 1'b0, c_far = 1'b0, c_hiz = 1'b0;
  logic [W-1:0] txp = '0, rxs = '0;
  logic [W-1:0] tx_ser_o, rx_par_o;
  logic         tx_ser_oe_o, rx_par_oe_o, rx_vld_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lbsel_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .lpbk_all_i(pin), .cfg_deep_i(c_deep),
    .cfg_shallow_i(c_sh), .cfg_far_i(c_far), .cfg_par_hiz_i(c_hiz),
    .tx_par_i(txp), .rx_ser_i(rxs), .tx_ser_o(tx_ser_o), .tx_ser_oe_o(tx_ser_oe_o),
    .rx_par_o(rx_par_o), .rx_par_oe_o(rx_par_oe_o), .rx_vld_o(rx_vld_o)
  );

  typedef struct packed {
    logic       sh, dp, fe;
    logic [W-1:0] tx, rx, e_rx, e_tx;
    logic       e_soe;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0,1'b0,1'b0,16'hA1A1,16'h5B5B,16'h5B5B,16'hA1A1,1'b1,4'd2},
    '{1'b0,1'b1,1'b0,16'h1234,16'hABCD,16'h1234,16'h1234,1'b0,4'd3},
    '{1'b1,1'b0,1'b0,16'h0F0F,16'hF0F0,16'h0F0F,16'h0F0F,1'b1,4'd5},
    '{1'b0,1'b0,1'b1,16'hDEAD,16'hBEEF,16'hBEEF,16'hBEEF,1'b1,4'd6},
    '{1'b1,1'b1,1'b0,16'h1111,16'h2222,16'h1111,16'h1111,1'b1,4'd7},
    '{1'b0,1'b1,1'b1,16'h3333,16'h4444,16'h3333,16'h3333,1'b0,4'd7},
    '{1'b1,1'b1,1'b1,16'h5555,16'h6666,16'h5555,16'h5555,1'b1,4'd7},
    '{1'b1,1'b0,1'b1,16'h7777,16'h8888,16'h7777,16'h7777,1'b1,4'd7}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    txp = 16'hCAFE; rxs = 16'hBABE;
    tick(); tick();
    chk("R1 tx_ser", tx_ser_o, '0);
    chk("R1 rx_par", rx_par_o, '0);
    chk("R1 oe/vld", {13'd0, tx_ser_oe_o, rx_par_oe_o, rx_vld_o}, '0);
    rst = 1'b0;
    tick();
    chk("R1 vld normal", {15'd0, rx_vld_o}, 16'd1);
    chk("R1 normal data", rx_par_o, 16'hBABE);

    // table walk: R2 R3 R5 R6 R7
    foreach (TBL[i]) begin
      c_sh = TBL[i].sh; c_deep = TBL[i].dp; c_far = TBL[i].fe;
      txp = TBL[i].tx; rxs = TBL[i].rx;
      tick(); tick();
      chk($sformatf("R%0d rx_par v%0d", TBL[i].req, i), rx_par_o, TBL[i].e_rx);
      chk($sformatf("R%0d tx_ser v%0d", TBL[i].req, i), tx_ser_o, TBL[i].e_tx);
      chk($sformatf("R%0d ser_oe v%0d", TBL[i].req, i), {15'd0, tx_ser_oe_o}, {15'd0, TBL[i].e_soe});
      chk($sformatf("R%0d vld v%0d", TBL[i].req, i), {15'd0, rx_vld_o}, 16'd1);
    end

    // R6: far-end ignores parallel transmit input
    c_sh = 0; c_deep = 0; c_far = 1; rxs = 16'h0042; txp = 16'h1111;
    tick(); tick();
    txp = 16'hFFFF;
    tick();
    chk("R6 tx ignored", tx_ser_o, 16'h0042);
    chk("R6 rx path", rx_par_o, 16'h0042);

    // R9: switch marks exactly one word invalid
    c_far = 0; rxs = 16'h0101; txp = 16'h0202;
    tick();
    chk("R9 vld low on switch", {15'd0, rx_vld_o}, 16'd0);
    chk("R9 new mode data", tx_ser_o, 16'h0202);
    tick();
    chk("R9 vld back", {15'd0, rx_vld_o}, 16'd1);

    // R4: global pin, two-flop synchronizer
    pin = 1'b1; txp = 16'h7E7E; rxs = 16'h0303;
    tick();
    chk("R4 edge1 still normal", {15'd0, tx_ser_oe_o}, 16'd1);
    tick();
    chk("R4 edge2 still normal", {15'd0, tx_ser_oe_o}, 16'd1);
    tick();
    chk("R4 edge3 deep oe", {15'd0, tx_ser_oe_o}, 16'd0);
    chk("R4 edge3 vld", {15'd0, rx_vld_o}, 16'd0);
    chk("R4 edge3 data", rx_par_o, 16'h7E7E);
    tick();
    chk("R4 settled vld", {15'd0, rx_vld_o}, 16'd1);
    // R4: pin overrides far-end after release and re-assert
    pin = 1'b0; tick(); tick(); tick(); tick();
    c_far = 1'b1; tick(); tick();
    chk("R4 far before pin", tx_ser_o, 16'h0303);
    pin = 1'b1; tick(); tick(); tick();
    chk("R4 pin over far oe", {15'd0, tx_ser_oe_o}, 16'd0);
    chk("R4 pin over far data", rx_par_o, 16'h7E7E);
    pin = 1'b0; c_far = 1'b0; tick(); tick(); tick(); tick();

    // R8: parallel output disable
    c_hiz = 1'b1;
    tick();
    chk("R8 par oe off", {15'd0, rx_par_oe_o}, 16'd0);
    chk("R8 vld unaffected", {15'd0, rx_vld_o}, 16'd1);
    c_hiz = 1'b0;
    tick();
    chk("R8 par oe on", {15'd0, rx_par_oe_o}, 16'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule